// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a circular list of transmit descriptors held in a local word-wide RAM and turns the buffers they point at into a byte stream. Software fills the RAM through its own port. Each descriptor takes two consecutive words: first a buffer byte address, then a control word holding the byte count and the flags. Descriptor `i` sits at words `DESC_BASE + 2*i` and `DESC_BASE + 2*i + 1`. A one-cycle `start` pulse sets the engine walking from its saved ring position. For each descriptor it reads the control word, reads the address, then sends the buffer bytes. When the buffer is done it writes the control word back with ownership returned to software.

A descriptor is ready for the engine when its used flag (control bit 31) is 0. The engine stops at the first descriptor whose used flag is 1. A frame may span several descriptors, and the end-of-frame flag (bit 15) closes it. If the engine meets a used descriptor while a frame is still open, the frame has run out of buffers. The engine then flags this on the frame's first descriptor, signals an abort on the stream and goes idle. A halt request takes effect at the next frame boundary. The engine does no framing and no CRC work. The no-CRC flag is only copied to a sideband output.

Top module: `txr_engine`

## Requirements
- R1: After reset `busy`, `out_valid`, `out_last` and `out_abort` are all 0, and the ring position is descriptor 0.
- R2: A `start` pulse while idle fetches the descriptor at the current position. If its used flag (bit 31) is 1, the engine returns to idle with no output and no RAM write.
- R3: For a descriptor with used flag 0, the engine emits exactly `ctrl[10:0]` bytes on `out_byte`, one per `out_valid` cycle. The bytes are taken from consecutive byte addresses starting at the descriptor's address word. Byte address `b` is bits `8*(b%4)+7 : 8*(b%4)` of RAM word `b/4`.
- R4: `out_last` is 1 only on the final byte of a descriptor whose end-of-frame flag (bit 15) is 1. `out_nocrc` equals that descriptor's bit 16 on every byte it emits.
- R5: After a descriptor's bytes are sent, its control word is rewritten with bit 31 set and every other bit unchanged.
- R6: The descriptor after one with wrap flag (bit 30) set is descriptor 0. The descriptor after index `RING_DEPTH-1` is also descriptor 0.
- R7: The engine keeps walking across frames until it reaches a used descriptor. Its position stays at that descriptor, so a later `start` resumes there.
- R8: If a used descriptor is reached while a frame is open (no end-of-frame seen yet), the first descriptor of that frame is rewritten with bits 31 and 27 set. `out_abort` pulses for one cycle and the engine goes idle, keeping its position at the used descriptor.
- R9: A `halt` pulse during a run lets the frame in progress finish, then the engine stops with `busy` low. The next `start` resumes at the following descriptor.
- R10: A `start` pulse while `busy` is 1 has no effect on the output stream or on the written-back words.
- R11: `busy` is 1 from the cycle after an accepted `start` until the engine has stopped.
- R12: A descriptor with byte count 0 emits no bytes but is still handed back as in R5 and still counts toward frame boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin walking the ring |
| halt | input | 1 | One-cycle request to stop at the next frame boundary |
| sw_we | input | 1 | Software write enable for the RAM |
| sw_addr | input | 8 | Software word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, one cycle after the address |
| busy | output | 1 | Engine is walking the ring |
| out_valid | output | 1 | A byte is present on `out_byte` |
| out_byte | output | 8 | Transmit data byte |
| out_last | output | 1 | Final byte of a frame |
| out_nocrc | output | 1 | The current buffer asked for no CRC |
| out_abort | output | 1 | One-cycle pulse: the frame ran out of buffers |

## Verification
The assertions assume that software does not write a descriptor or a buffer the engine currently owns, and that the software port and the engine never write the same word in the same cycle. They also assume that a ring of ready descriptors ends in a used one. The bench rebuilds the descriptors and starts the engine only while `busy` is low. It places buffers in a region apart from the ring and limits each chain to fewer descriptors than the ring holds. It sets random wrap flags only where the chain cannot fold back onto itself. Halt and repeated start pulses are driven only while a run is known to be in progress.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;

  localparam int LEN_W   = 11;
  localparam int B_EOF   = 15;
  localparam int B_NOCRC = 16;
  localparam int B_EXH   = 27;
  localparam int B_UNDR  = 28;
  localparam int B_RETRY = 29;
  localparam int B_WRAP  = 30;
  localparam int B_USED  = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_CA, S_CD, S_AA, S_AD, S_BA, S_BD, S_WB, S_ERR
  } walk_st_t;

  function automatic int unsigned desc_slot(int unsigned base, int unsigned idx, bit ctrl_word);
    return base + 2 * idx + (ctrl_word ? 1 : 0);
  endfunction

  function automatic int unsigned ring_next(int unsigned idx, int unsigned depth, logic wrap);
    return (wrap || idx == depth - 1) ? 0 : idx + 1;
  endfunction

  function automatic logic [7:0] lane_byte(logic [31:0] w, logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] sent_word(logic [31:0] c);
    return c | (32'd1 << B_USED);
  endfunction

  function automatic logic [31:0] exhaust_word(logic [31:0] c);
    return c | (32'd1 << B_USED) | (32'd1 << B_EXH);
  endfunction

endpackage

// File: rtl/txr_ram.sv
`timescale 1ns/1ps
module txr_ram #(
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [31:0]   b_wdata,
  output logic [31:0]   b_rdata
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/txr_walker.sv
`timescale 1ns/1ps
module txr_walker
  import txr_pkg::*;
#(
  parameter int AW         = 8,
  parameter int RING_DEPTH = 16,
  parameter int DESC_BASE  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          halt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic          out_last,
  output logic          out_nocrc,
  output logic          out_abort
);

  localparam int IW  = $clog2(RING_DEPTH);
  localparam int BAW = AW + 2;

  walk_st_t          st;
  logic [IW-1:0]     idx, first_idx;
  logic [BAW-1:0]    ptr;
  logic [LEN_W-1:0]  cnt;
  logic [31:0]       ctrl, first_ctrl;
  logic              in_frame, halt_pend;
  logic              last_beat, frame_closes;

  assign last_beat    = (cnt == LEN_W'(1));
  assign frame_closes = ctrl[B_EOF];

  always_comb begin
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    case (st)
      S_CA:  mem_addr = AW'(desc_slot(DESC_BASE, 32'(idx), 1'b1));
      S_AA:  mem_addr = AW'(desc_slot(DESC_BASE, 32'(idx), 1'b0));
      S_BA:  mem_addr = ptr[BAW-1:2];
      S_WB: begin
        mem_addr  = AW'(desc_slot(DESC_BASE, 32'(idx), 1'b1));
        mem_we    = 1'b1;
        mem_wdata = sent_word(ctrl);
      end
      S_ERR: begin
        mem_addr  = AW'(desc_slot(DESC_BASE, 32'(first_idx), 1'b1));
        mem_we    = 1'b1;
        mem_wdata = exhaust_word(first_ctrl);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      first_idx  <= '0;
      ptr        <= '0;
      cnt        <= '0;
      ctrl       <= '0;
      first_ctrl <= '0;
      in_frame   <= 1'b0;
      halt_pend  <= 1'b0;
    end else begin
      halt_pend <= halt_pend | halt;
      case (st)
        S_IDLE: begin
          halt_pend <= 1'b0;
          if (start) st <= S_CA;
        end
        S_CA: st <= S_CD;
        S_CD: begin
          if (mem_rdata[B_USED]) begin
            st <= in_frame ? S_ERR : S_IDLE;
          end else begin
            ctrl <= mem_rdata;
            st   <= S_AA;
          end
        end
        S_AA: st <= S_AD;
        S_AD: begin
          ptr <= mem_rdata[BAW-1:0];
          cnt <= ctrl[LEN_W-1:0];
          st  <= (ctrl[LEN_W-1:0] == '0) ? S_WB : S_BA;
        end
        S_BA: st <= S_BD;
        S_BD: begin
          ptr <= ptr + BAW'(1);
          cnt <= cnt - LEN_W'(1);
          st  <= last_beat ? S_WB : S_BA;
        end
        S_WB: begin
          if (!in_frame) begin
            first_idx  <= idx;
            first_ctrl <= ctrl;
          end
          in_frame <= !frame_closes;
          idx      <= IW'(ring_next(32'(idx), RING_DEPTH, ctrl[B_WRAP]));
          st       <= (frame_closes && (halt_pend || halt)) ? S_IDLE : S_CA;
        end
        S_ERR: begin
          in_frame <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign out_valid = (st == S_BD);
  assign out_byte  = lane_byte(mem_rdata, ptr[1:0]);
  assign out_last  = out_valid && last_beat && ctrl[B_EOF];
  assign out_nocrc = out_valid && ctrl[B_NOCRC];
  assign out_abort = (st == S_ERR);

endmodule

// File: rtl/txr_engine.sv
`timescale 1ns/1ps
module txr_engine #(
  parameter int MEM_WORDS  = 256,
  parameter int RING_DEPTH = 16,
  parameter int DESC_BASE  = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        halt,
  input  logic        sw_we,
  input  logic [7:0]  sw_addr,
  input  logic [31:0] sw_wdata,
  output logic [31:0] sw_rdata,
  output logic        busy,
  output logic        out_valid,
  output logic [7:0]  out_byte,
  output logic        out_last,
  output logic        out_nocrc,
  output logic        out_abort
);

  localparam int AW = $clog2(MEM_WORDS);

  logic [AW-1:0] eng_addr;
  logic          eng_we;
  logic [31:0]   eng_wdata;
  logic [31:0]   eng_rdata;

  txr_ram #(.WORDS(MEM_WORDS), .AW(AW)) u_ram (
    .clk     (clk),
    .a_addr  (eng_addr),
    .a_we    (eng_we),
    .a_wdata (eng_wdata),
    .a_rdata (eng_rdata),
    .b_addr  (sw_addr[AW-1:0]),
    .b_we    (sw_we),
    .b_wdata (sw_wdata),
    .b_rdata (sw_rdata)
  );

  txr_walker #(.AW(AW), .RING_DEPTH(RING_DEPTH), .DESC_BASE(DESC_BASE)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .halt      (halt),
    .mem_addr  (eng_addr),
    .mem_we    (eng_we),
    .mem_wdata (eng_wdata),
    .mem_rdata (eng_rdata),
    .busy      (busy),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_last  (out_last),
    .out_nocrc (out_nocrc),
    .out_abort (out_abort)
  );

endmodule

// File: rtl/txr_engine_chk.sv
`timescale 1ns/1ps
module txr_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        out_valid,
  input logic        out_last,
  input logic        out_abort,
  input logic        eng_we,
  input logic [31:0] eng_wdata
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !out_abort)); // R1

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_we); // R2

  AST_LAST_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R4

  AST_WB_RETURNS_OWNERSHIP: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> eng_wdata[31]); // R5

  AST_ABORT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |=> !busy); // R8

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R11

endmodule

bind txr_engine txr_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .out_valid (out_valid),
  .out_last  (out_last),
  .out_abort (out_abort),
  .eng_we    (eng_we),
  .eng_wdata (eng_wdata)
);

// File: tb/txr_engine_bench.sv
`timescale 1ns/1ps
module txr_engine_bench;

  localparam int MW = 256;
  localparam int RD = 16;

  logic        clk = 1'b0;
  logic        rst_n, start, halt, sw_we;
  logic [7:0]  sw_addr;
  logic [31:0] sw_wdata, sw_rdata;
  logic        busy, out_valid, out_last, out_nocrc, out_abort;
  logic [7:0]  out_byte;

  always #10 clk = ~clk;

  txr_engine u_txr_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .busy(busy), .out_valid(out_valid), .out_byte(out_byte),
    .out_last(out_last), .out_nocrc(out_nocrc), .out_abort(out_abort)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;
  logic [31:0] bmem [MW];
  int exp_pos = 0;
  logic [7:0] exp_b[$], cap_b[$];
  bit exp_l[$], cap_l[$], exp_n[$], cap_n[$];
  int exp_abort, cap_abort;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000) wd_hit <= 1'b1;
  end

  always @(negedge clk) begin
    if (out_valid) begin
      cap_b.push_back(out_byte);
      cap_l.push_back(out_last);
      cap_n.push_back(out_nocrc);
    end
    if (out_abort) cap_abort = cap_abort + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sw_write(input int a, input logic [31:0] d);
    sw_we = 1'b1; sw_addr = 8'(a); sw_wdata = d; bmem[a] = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_read(input int a, output logic [31:0] d);
    sw_addr = 8'(a);
    @(negedge clk);
    d = sw_rdata;
  endtask

  function automatic int nxt(input int p, input logic [31:0] c);
    return (c[30] || p == RD - 1) ? 0 : p + 1;
  endfunction

  task automatic model(input bit hlt);
    int p = exp_pos;
    bit inf = 1'b0;
    int first = 0;
    exp_b.delete(); exp_l.delete(); exp_n.delete();
    exp_abort = 0;
    for (int it = 0; it < 64; it++) begin
      logic [31:0] c = bmem[2*p+1];
      logic [31:0] a = bmem[2*p];
      int len = int'(c[10:0]);
      if (c[31]) begin
        if (inf) begin
          bmem[2*first+1] = bmem[2*first+1] | 32'h8800_0000;
          exp_abort = 1;
        end
        break;
      end
      for (int k = 0; k < len; k++) begin
        int ba = (int'(a[9:0]) + k) % 1024;
        logic [31:0] w = bmem[ba / 4];
        exp_b.push_back(w[8*(ba%4) +: 8]);
        exp_l.push_back(k == len - 1 && c[15]);
        exp_n.push_back(c[16]);
      end
      bmem[2*p+1] = c | 32'h8000_0000;
      if (!inf) first = p;
      inf = !c[15];
      p = nxt(p, c);
      if (hlt && !inf) break;
    end
    exp_pos = p;
  endtask

  task automatic clear_ring();
    for (int i = 0; i < RD; i++) begin
      sw_write(2*i, 32'h0);
      sw_write(2*i+1, (i == RD - 1) ? 32'hC000_0000 : 32'h8000_0000);
    end
  endtask

  task automatic build(input int nfr, input bit exhaust, input bit zero_first);
    int p = exp_pos;
    bit wrap_ok = (exp_pos >= 10);
    clear_ring();
    for (int f = 0; f < nfr; f++) begin
      int nb = 1 + int'($urandom % 3);
      for (int b = 0; b < nb; b++) begin
        logic [31:0] c;
        int len = (zero_first && f == 0 && b == 0) ? 0 : int'($urandom % 25);
        int ad = 256 + int'($urandom % 700);
        c = 32'(len);
        if (b == nb - 1 && !(exhaust && f == nfr - 1)) c[15] = 1'b1;
        c[16] = $urandom % 2;
        if (p == RD - 1 || (wrap_ok && ($urandom % 4 == 0))) c[30] = 1'b1;
        sw_write(2*p, 32'(ad));
        sw_write(2*p+1, c);
        p = nxt(p, c);
      end
    end
  endtask

  task automatic run(input bit do_halt, input bit do_restart, input string tag);
    int nb_mis = 0, nl_mis = 0, nn_mis = 0;
    model(do_halt);
    cap_b.delete(); cap_l.delete(); cap_n.delete();
    cap_abort = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", {tag, " busy after start"}, busy, 1);
    if (do_halt) begin
      halt = 1'b1;
      @(negedge clk);
      halt = 1'b0;
    end
    if (do_restart && exp_b.size() >= 4) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy && !wd_hit) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(cap_b.size() == exp_b.size(), "R3", {tag, " byte count"}, cap_b.size(), exp_b.size());
    for (int i = 0; i < cap_b.size() && i < exp_b.size(); i++) begin
      if (cap_b[i] != exp_b[i]) nb_mis++;
      if (cap_l[i] != exp_l[i]) nl_mis++;
      if (cap_n[i] != exp_n[i]) nn_mis++;
    end
    chk(nb_mis == 0, "R3 R7", {tag, " byte mismatches"}, nb_mis, 0);
    chk(nl_mis == 0, "R4", {tag, " last flag mismatches"}, nl_mis, 0);
    chk(nn_mis == 0, "R4", {tag, " nocrc flag mismatches"}, nn_mis, 0);
    chk(cap_abort == exp_abort, "R8", {tag, " abort pulses"}, cap_abort, exp_abort);
    for (int i = 0; i < RD; i++) begin
      logic [31:0] d;
      sw_read(2*i+1, d);
      chk(d == bmem[2*i+1], "R5 R6 R12", $sformatf("%s ctrl word %0d", tag, i), d, bmem[2*i+1]);
    end
  endtask

  initial begin
    void'($urandom(32'd7341));
    rst_n = 1'b0; start = 1'b0; halt = 1'b0;
    sw_we = 1'b0; sw_addr = '0; sw_wdata = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(out_valid == 1'b0 && out_abort == 1'b0 && out_last == 1'b0, "R1", "stream quiet in reset",
        {out_valid, out_abort, out_last}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "idle after reset", busy, 0);
    for (int w = 64; w < MW; w++) sw_write(w, $urandom);

    // R2: nothing released, start must not emit or write
    clear_ring();
    run(1'b0, 1'b0, "R2 all used");
    // R12: zero-length first buffer
    build(2, 1'b0, 1'b1);
    run(1'b0, 1'b0, "R12 zero length");
    // R9: halt after the first frame, then resume
    build(3, 1'b0, 1'b0);
    run(1'b1, 1'b0, "R9 halt");
    run(1'b0, 1'b0, "R9 resume");
    // R8: open frame meets a used descriptor
    build(2, 1'b1, 1'b0);
    run(1'b0, 1'b0, "R8 exhaust");
    // R10: extra start while busy
    build(2, 1'b0, 1'b0);
    run(1'b0, 1'b1, "R10 restart");
    // R6 R7: random chains, wrap covered as the position walks round
    for (int s = 0; s < 24; s++) begin
      int nfr = 1 + int'($urandom % 3);
      bit ex = ($urandom % 5 == 0);
      bit hl = ($urandom % 5 == 0) && nfr > 1;
      bit rs = ($urandom % 4 == 0);
      build(nfr, ex, 1'b0);
      run(hl, rs, $sformatf("R6 R7 random %0d", s));
    end

    if (wd_hit) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (wd_hit);
    repeat (20000) @(negedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog hang actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule